// File: doc/BRIEF.md
# PCM Clock and Frame-Sync Generator

This block derives every timing signal of a telephony PCM codec port from one core clock. The core clock runs at twice the 4.096 MHz reference, so a 4.096 MHz bit clock can still come out of a register. One free-running counter spans a full 8 kHz frame, which is 512 reference periods or 1024 core cycles. Each output is a registered function of the counter's next value, so every edge lines up with the frame boundary.

The bit clock rate comes from a 3-bit select. The frame-sync pulse is high for one to eight bit-clock periods: one period is short-frame operation and more than one is long-frame operation. The master clock is either a fixed 256 kHz or a copy of the bit clock. The transmit frame sync always carries the generated pulse. The receive frame sync can follow that pulse or be held high or low. A change to the rate or the width only takes effect at the next frame start, so no frame ever carries a partial pulse.

Top module: `pcm_timing_gen`

## Requirements
- R1: While `rst_ni` is low, all four outputs are low. The first core clock edge after release starts a frame, so right after that edge `bclk_o`, `mclk_o` and `fsx_o` are high (and `fsr_o` is high in follow mode).
- R2: `rate_sel_i` sets the bit-clock half period in core cycles: 0→1, 1→2, 2→4, 3→8, 4→32, 5→64. Codes 6 and 7 act as 5. The bit clock starts high at each frame start.
- R3: A frame lasts exactly 1024 core cycles, and `fsx_o` rises exactly once per frame, at the frame start.
- R4: `fsx_o` stays high for W bit-clock periods, where W = `width_sel_i` + 1. It rises and falls together with a rising edge of `bclk_o`.
- R5: When the selected rate leaves only 8 bit clocks per frame (codes 5 to 7), a width of 8 is clamped to 7.
- R6: A change of `rate_sel_i` or `width_sel_i` in the middle of a frame leaves the current frame unchanged. It applies from the next frame start.
- R7: With `mclk_sel_i` = 0, `mclk_o` has a period of 32 core cycles and is high for the first 16 cycles of each frame. With `mclk_sel_i` = 1, `mclk_o` equals `bclk_o`. The select applies from the next core clock edge.
- R8: `fsr_mode_i` sets the receive sync: 00 follows the generated pulse, 01 holds it high, 10 holds it low, 11 follows the pulse. The mode applies from the next core clock edge.
- R9: `fsx_o` carries the generated pulse in every receive-sync mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock, twice the reference rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rate_sel_i | input | 3 | Bit-clock rate code |
| width_sel_i | input | WIDTH_W (3) | Frame-sync width minus one, in bit clocks |
| mclk_sel_i | input | 1 | 0: fixed 256 kHz master clock, 1: bit clock |
| fsr_mode_i | input | 2 | Receive frame-sync mode |
| bclk_o | output | 1 | Bit clock |
| mclk_o | output | 1 | Master clock |
| fsx_o | output | 1 | Transmit frame sync |
| fsr_o | output | 1 | Receive frame sync |

## Verification
The bench builds the block with its default parameters: a 1024-cycle frame, a 3-bit width field and a master-clock divide of 16. With these values every rate code can be reached within one frame. This includes the 8-bit-clock frame where the width clamp applies, and both aliased codes. Whole frames are measured at the ports while a mid-frame setting change is applied, which shows that the old settings last until the frame start.

// File: rtl/pcm_timing_pkg.sv
package pcm_timing_pkg;
  localparam int RATE_W = 3;
  localparam int SH_W   = 3;

  typedef enum logic [1:0] {
    FSR_FOLLOW  = 2'b00,
    FSR_HIGH    = 2'b01,
    FSR_LOW     = 2'b10,
    FSR_FOLLOW2 = 2'b11
  } fsr_mode_e;

  // rate code -> log2 of half period in core cycles
  function automatic logic [SH_W-1:0] rate_shift(input logic [RATE_W-1:0] sel);
    case (sel)
      3'd0:    return 3'd0;
      3'd1:    return 3'd1;
      3'd2:    return 3'd2;
      3'd3:    return 3'd3;
      3'd4:    return 3'd5;
      default: return 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/pcm_tick_counter.sv
module pcm_tick_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_n_o,
  output logic             boundary_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_n_o    = cnt_q + 1'b1;
  assign boundary_o = (cnt_n_o == '0);

  // reset to all ones so the first edge after release opens frame 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_n_o;
  end

  p_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '1) |=> (cnt_q == '0));
endmodule

// File: rtl/pcm_frame_cfg.sv
module pcm_frame_cfg
  import pcm_timing_pkg::*;
#(
  parameter int CNT_W   = 10,
  parameter int WIDTH_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               boundary_i,
  input  logic [RATE_W-1:0]  rate_sel_i,
  input  logic [WIDTH_W-1:0] width_sel_i,
  output logic [SH_W-1:0]    shift_o,
  output logic [WIDTH_W:0]   width_o
);
  localparam int WV_W = WIDTH_W + 1;

  logic [SH_W-1:0] shift_q, sh_in;
  logic [WV_W-1:0] width_q, w_in;
  int unsigned     lim;

  always_comb begin
    sh_in = rate_shift(rate_sel_i);
    w_in  = {1'b0, width_sel_i} + WV_W'(1);
    // bit clocks per frame minus one keeps a low interval
    lim   = (32'd1 << (CNT_W - 1 - int'(sh_in))) - 32'd1;
    if (32'(w_in) > lim) w_in = WV_W'(lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= SH_W'(1);
      width_q <= WV_W'(1);
    end else if (boundary_i) begin
      shift_q <= sh_in;
      width_q <= w_in;
    end
  end

  assign shift_o = boundary_i ? sh_in : shift_q;
  assign width_o = boundary_i ? w_in  : width_q;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary_i |=> ($stable(shift_q) && $stable(width_q)));

  p_clamp_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_q == SH_W'(CNT_W - 4)) |-> (width_q < WV_W'(8)));
endmodule

// File: rtl/pcm_wave_gen.sv
module pcm_wave_gen
  import pcm_timing_pkg::*;
#(
  parameter int CNT_W    = 10,
  parameter int WIDTH_W  = 3,
  parameter int MCLK_DIV = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [CNT_W-1:0]   cnt_n_i,
  input  logic [SH_W-1:0]    shift_i,
  input  logic [WIDTH_W:0]   width_i,
  input  logic               mclk_sel_i,
  input  logic [1:0]         fsr_mode_i,
  output logic               bclk_o,
  output logic               mclk_o,
  output logic               fsx_o,
  output logic               fsr_o
);
  localparam int MCLK_BIT = $clog2(MCLK_DIV);

  logic [CNT_W-1:0] half_cnt, bit_idx;
  logic             bclk_n, mclk_n, fsx_n, fsr_n;
  fsr_mode_e        mode;
  logic             live_q;

  always_comb begin
    mode     = fsr_mode_e'(fsr_mode_i);
    half_cnt = cnt_n_i >> shift_i;
    bit_idx  = half_cnt >> 1;
    bclk_n   = ~half_cnt[0];
    fsx_n    = (bit_idx < CNT_W'(width_i));
    mclk_n   = mclk_sel_i ? bclk_n : ~cnt_n_i[MCLK_BIT];
    case (mode)
      FSR_HIGH: fsr_n = 1'b1;
      FSR_LOW:  fsr_n = 1'b0;
      default:  fsr_n = fsx_n;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bclk_o <= 1'b0;
      mclk_o <= 1'b0;
      fsx_o  <= 1'b0;
      fsr_o  <= 1'b0;
      live_q <= 1'b0;
    end else begin
      bclk_o <= bclk_n;
      mclk_o <= mclk_n;
      fsx_o  <= fsx_n;
      fsr_o  <= fsr_n;
      live_q <= 1'b1;
    end
  end

  p_fs_rise_on_bclk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fsx_o) |-> $rose(bclk_o));

  p_fs_fall_on_bclk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fsx_o) |-> $rose(bclk_o));

  p_fsr_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(fsr_mode_i) == 2'b01) |-> fsr_o);

  p_fsr_low_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(fsr_mode_i) == 2'b10) |-> !fsr_o);
endmodule

// File: rtl/pcm_timing_gen.sv
module pcm_timing_gen
  import pcm_timing_pkg::*;
#(
  parameter int FRAME_REFS = 512,
  parameter int WIDTH_W    = 3,
  parameter int MCLK_DIV   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0]         rate_sel_i,
  input  logic [WIDTH_W-1:0] width_sel_i,
  input  logic               mclk_sel_i,
  input  logic [1:0]         fsr_mode_i,
  output logic               bclk_o,
  output logic               mclk_o,
  output logic               fsx_o,
  output logic               fsr_o
);
  localparam int CNT_W = $clog2(2 * FRAME_REFS);

  logic [CNT_W-1:0] cnt_n;
  logic             boundary;
  logic [SH_W-1:0]  shift;
  logic [WIDTH_W:0] width;

  pcm_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_n_o    (cnt_n),
    .boundary_o (boundary)
  );

  pcm_frame_cfg #(.CNT_W(CNT_W), .WIDTH_W(WIDTH_W)) u_cfg (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boundary_i  (boundary),
    .rate_sel_i  (rate_sel_i),
    .width_sel_i (width_sel_i),
    .shift_o     (shift),
    .width_o     (width)
  );

  pcm_wave_gen #(.CNT_W(CNT_W), .WIDTH_W(WIDTH_W), .MCLK_DIV(MCLK_DIV)) u_wave (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cnt_n_i    (cnt_n),
    .shift_i    (shift),
    .width_i    (width),
    .mclk_sel_i (mclk_sel_i),
    .fsr_mode_i (fsr_mode_i),
    .bclk_o     (bclk_o),
    .mclk_o     (mclk_o),
    .fsx_o      (fsx_o),
    .fsr_o      (fsr_o)
  );
endmodule

// File: tb/pcm_timing_gen_test.sv
`timescale 1ns/1ps
module pcm_timing_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] rate = 3'd1;
  logic [2:0] wsel = 3'd0;
  logic       msel = 1'b0;
  logic [1:0] fmode = 2'b00;
  logic       bclk, mclk, fsx, fsr;

  int total = 0, bad = 0;
  bit live = 0, done = 0;

  // model state
  int mp = 1023, m_half = 2, m_w = 1;
  int e_bclk = 0, e_mclk = 0, e_fsx = 0, e_fsr = 0;

  always #2.5 clk = ~clk;

  pcm_timing_gen uut (
    .clk_i(clk), .rst_ni(rst_n), .rate_sel_i(rate), .width_sel_i(wsel),
    .mclk_sel_i(msel), .fsr_mode_i(fmode),
    .bclk_o(bclk), .mclk_o(mclk), .fsx_o(fsx), .fsr_o(fsr)
  );

  function automatic int half_of(input int r);
    case (r)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      4: return 32;
      default: return 64;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d (p=%0d)", tag, act, exp, mp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mp = 1023;
      e_bclk = 0; e_mclk = 0; e_fsx = 0; e_fsr = 0;
    end else begin
      int nb;
      mp = (mp + 1) % 1024;
      if (mp == 0) begin
        m_half = half_of(int'(rate));
        m_w = int'(wsel) + 1;
        nb = 1024 / (2 * m_half);
        if (m_w >= nb) m_w = nb - 1;
      end
      e_bclk = ((mp / m_half) % 2 == 0) ? 1 : 0;
      e_fsx  = (mp < m_w * 2 * m_half) ? 1 : 0;
      e_mclk = msel ? e_bclk : (((mp / 16) % 2 == 0) ? 1 : 0);
      e_fsr  = (fmode == 2'b01) ? 1 : (fmode == 2'b10) ? 0 : e_fsx;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R2 bclk", int'(bclk), e_bclk);
      chk("R4 fsx", int'(fsx), e_fsx);
      chk("R7 mclk", int'(mclk), e_mclk);
      chk("R8 fsr", int'(fsr), e_fsr);
    end
  end

  task automatic set_cfg(input int r, input int w, input int m, input int f);
    @(negedge clk);
    rate = 3'(r); wsel = 3'(w); msel = 1'(m); fmode = 2'(f);
  endtask

  task automatic measure(input int chg_at, input int nr, input int nw,
                         output int hi, output int brise, output int mrise, output int frise);
    int pb = 0, pm = 0, pf = 0;
    hi = 0; brise = 0; mrise = 0; frise = 0;
    @(negedge clk);
    while (mp != 0) @(negedge clk);
    for (int i = 0; i < 1024; i++) begin
      if (fsx) hi++;
      if (bclk && !pb) brise++;
      if (mclk && !pm) mrise++;
      if (fsx && !pf) frise++;
      pb = int'(bclk); pm = int'(mclk); pf = int'(fsx);
      if (i == chg_at) begin rate = 3'(nr); wsel = 3'(nw); end
      @(negedge clk);
    end
  endtask

  initial begin
    int hi, br, mr, fr;
    repeat (3) @(negedge clk);
    chk("R1 reset bclk", int'(bclk), 0);
    chk("R1 reset mclk", int'(mclk), 0);
    chk("R1 reset fsx", int'(fsx), 0);
    chk("R1 reset fsr", int'(fsr), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 first bclk", int'(bclk), 1);
    chk("R1 first mclk", int'(mclk), 1);
    chk("R1 first fsx", int'(fsx), 1);
    chk("R1 first fsr", int'(fsr), 1);
    live = 1;

    measure(-1, 0, 0, hi, br, mr, fr);
    chk("R4 short width", hi, 4);
    chk("R2 rate1 rises", br, 256);
    chk("R7 fixed mclk rises", mr, 32);
    chk("R3 one fs rise", fr, 1);

    set_cfg(0, 3, 1, 1);
    measure(-1, 0, 3, hi, br, mr, fr);
    chk("R4 width4 rate0", hi, 8);
    chk("R2 rate0 rises", br, 512);
    chk("R7 mclk as bclk", mr, 512);
    chk("R9 fsx with fsr high", fr, 1);
    chk("R8 fsr held high", int'(fsr), 1);

    set_cfg(2, 7, 0, 2);
    measure(-1, 2, 7, hi, br, mr, fr);
    chk("R4 width8 rate2", hi, 64);
    chk("R2 rate2 rises", br, 128);
    chk("R9 fsx with fsr low", fr, 1);

    set_cfg(3, 4, 0, 3);
    measure(-1, 3, 4, hi, br, mr, fr);
    chk("R4 width5 rate3", hi, 80);
    chk("R2 rate3 rises", br, 64);

    set_cfg(4, 7, 1, 0);
    measure(-1, 4, 7, hi, br, mr, fr);
    chk("R4 width8 rate4", hi, 512);
    chk("R2 rate4 rises", br, 16);

    set_cfg(5, 7, 0, 0);
    measure(-1, 5, 7, hi, br, mr, fr);
    chk("R5 clamp to 7", hi, 896);
    chk("R2 rate5 rises", br, 8);
    chk("R3 fs rise clamp", fr, 1);

    set_cfg(7, 2, 0, 0);
    measure(-1, 7, 2, hi, br, mr, fr);
    chk("R2 alias code7", hi, 384);
    chk("R2 alias rises", br, 8);

    set_cfg(3, 1, 0, 0);
    measure(-1, 3, 1, hi, br, mr, fr);
    chk("R6 base frame", hi, 32);
    measure(300, 0, 5, hi, br, mr, fr);
    chk("R6 old width kept", hi, 32);
    chk("R6 old rate kept", br, 64);
    measure(-1, 0, 5, hi, br, mr, fr);
    chk("R6 new width", hi, 12);
    chk("R6 new rate", br, 512);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule